// File: doc/BRIEF.md
# UART Transmit-Empty Interrupt Qualifier

This block decides when a UART raises its "transmit holding register empty" interrupt. It watches the occupancy of a 16-entry transmit FIFO, the CPU's writes into the transmit holding register and the CPU's reads of the interrupt identification register. When the FIFO drains, the interrupt is raised at once if software recently loaded at least two characters. Otherwise the interrupt waits for one character time, stop bit excluded, so that software can refill the FIFO at start-up or after single-character bursts without a needless interrupt.

The block also merges this source with three higher-priority receive-side sources, which reach it as plain pending inputs. It reports a combined pending flag and the 3-bit identification code that software reads. The delay is counted in 16x baud ticks, and its length follows the configured data width and parity.

Top module: `uart_thre_qual`

## Requirements
- R1: While reset is asserted, thre_flag and irq_pend are 0 and int_id is 3'b000.
- R2: On the delayed path, thre_flag stays low until exactly (1 + data bits + parity bit) x 16 baud ticks have been counted after the FIFO went empty. It rises on the clock edge that samples the last of those ticks.
- R3: The data width comes from data_bits_sel: 00 selects 5 bits, 01 selects 6, 10 selects 7 and 11 selects 8. parity_en = 1 adds one bit to the delay length.
- R4: If fifo_level reached 2 or more since the last time the interrupt was raised, thre_flag rises on the first clock edge that samples fifo_level = 0.
- R5: Raising the interrupt clears the "held two or more" history. A later drain from a FIFO that held only one character uses the delayed path.
- R6: A thr_wr pulse clears the pending interrupt on that clock edge.
- R7: A thr_wr during the delay cancels it. A later empty event starts a new full-length delay.
- R8: An iir_rd while int_id = 3'b001 clears the pending interrupt. The interrupt does not rise again while the FIFO stays empty.
- R9: An iir_rd while a higher-priority source is shown leaves this interrupt pending.
- R10: int_id follows this priority: rls_pend gives 3'b011, then rda_pend gives 3'b010, then cto_pend gives 3'b110, then this source gives 3'b001. With nothing pending, int_id is 3'b000 and irq_pend is 0.
- R11: While thre_ie is low, the interrupt is hidden from thre_flag, int_id and irq_pend, but the qualifier state keeps updating. Raising thre_ie shows an interrupt that became pending meanwhile.
- R12: After reset the history is clear and the FIFO is taken as empty, so the first interrupt uses the delayed path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_level | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| thr_wr | input | 1 | CPU write into the transmit holding register |
| iir_rd | input | 1 | CPU read of the interrupt identification register |
| baud_tick | input | 1 | 16x oversampling baud tick |
| data_bits_sel | input | 2 | Data width select, 00 = 5 bits up to 11 = 8 bits |
| parity_en | input | 1 | Parity bit present in the frame |
| thre_ie | input | 1 | Enable for the transmit-empty interrupt |
| rls_pend | input | 1 | Line-status interrupt pending (highest priority) |
| rda_pend | input | 1 | Receive-data interrupt pending |
| cto_pend | input | 1 | Character-timeout interrupt pending |
| thre_flag | output | 1 | Transmit-empty interrupt pending and enabled |
| irq_pend | output | 1 | Any interrupt shown |
| int_id | output | 3 | Identification code of the highest-priority source |

## Verification
A lost or stale history bit changes the path that the next drain takes. The interrupt then appears one clock after the empty FIFO when it should have waited a whole character, or the reverse, so the fault shows at the first empty event. A delay counter that is not restarted fires early, after fewer baud ticks than the frame needs, within a single character time. A "raised" marker that is never cleared shows as an interrupt that reappears after an identification read or never returns after a refill. A priority fault shows at once in int_id.

// File: rtl/uart_thre_pkg.sv
package uart_thre_pkg;

    typedef enum logic [2:0] {
        ID_NONE = 3'b000,
        ID_THRE = 3'b001,
        ID_RDA  = 3'b010,
        ID_RLS  = 3'b011,
        ID_CTO  = 3'b110
    } int_id_e;

    typedef struct packed {
        logic thre;     // interrupt pending
        logic fired;    // raised since FIFO last became non-empty
        logic held2;    // FIFO held two or more since last raise
        logic wait_on;  // delayed path counting
    } qual_st_t;

endpackage

// File: rtl/thre_char_timer.sv
module thre_char_timer #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] dbits,
    input  logic       par_en,
    output logic       expire
);
    localparam int MAX_BITS = 10;
    localparam int CNT_W    = $clog2(MAX_BITS * OVS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] target;
    logic [3:0]       nbits;

    // start bit + (5..8) data bits + optional parity
    always_comb begin
        nbits  = 4'd6 + {2'b00, dbits} + {3'b000, par_en};
        target = CNT_W'(nbits) * CNT_W'(OVS);
        expire = run && tick && (cnt_q == target - CNT_W'(1));
        cnt_d  = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (tick)
            cnt_d = expire ? '0 : cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/thre_id_prio.sv
module thre_id_prio
    import uart_thre_pkg::*;
(
    input  logic    rls,
    input  logic    rda,
    input  logic    cto,
    input  logic    thre,
    output int_id_e id,
    output logic    any
);
    always_comb begin
        if (rls)       id = ID_RLS;
        else if (rda)  id = ID_RDA;
        else if (cto)  id = ID_CTO;
        else if (thre) id = ID_THRE;
        else           id = ID_NONE;
        any = rls | rda | cto | thre;
    end
endmodule

// File: rtl/uart_thre_qual.sv
module uart_thre_qual
    import uart_thre_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             baud_tick,
    input  logic [1:0]       data_bits_sel,
    input  logic             parity_en,
    input  logic             thre_ie,
    input  logic             rls_pend,
    input  logic             rda_pend,
    input  logic             cto_pend,
    output logic             thre_flag,
    output logic             irq_pend,
    output logic [2:0]       int_id
);
    qual_st_t st_d, st_q;
    logic     empty, expire, thre_vis, thre_shown;
    int_id_e  id_w;

    thre_char_timer #(.OVS(OVS)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.wait_on),
        .tick   (baud_tick),
        .dbits  (data_bits_sel),
        .par_en (parity_en),
        .expire (expire)
    );

    assign thre_vis = st_q.thre & thre_ie;

    thre_id_prio prio_i (
        .rls  (rls_pend),
        .rda  (rda_pend),
        .cto  (cto_pend),
        .thre (thre_vis),
        .id   (id_w),
        .any  (irq_pend)
    );

    assign int_id     = id_w;
    assign thre_flag  = thre_vis;
    assign thre_shown = (id_w == ID_THRE);
    assign empty      = (fifo_level == '0);

    always_comb begin
        st_d = st_q;
        if (fifo_level >= LVL_W'(2))
            st_d.held2 = 1'b1;
        if (!empty) begin
            st_d.fired   = 1'b0;
            st_d.wait_on = 1'b0;
        end else if (!st_q.fired && !st_q.wait_on && !thr_wr) begin
            if (st_q.held2) begin
                st_d.thre  = 1'b1;
                st_d.fired = 1'b1;
                st_d.held2 = 1'b0;
            end else begin
                st_d.wait_on = 1'b1;
            end
        end
        if (st_q.wait_on && expire && empty) begin
            st_d.thre    = 1'b1;
            st_d.fired   = 1'b1;
            st_d.held2   = 1'b0;
            st_d.wait_on = 1'b0;
        end
        if (thr_wr) begin
            st_d.thre    = 1'b0;
            st_d.wait_on = 1'b0;
        end
        if (iir_rd && thre_shown)
            st_d.thre = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/thre_qual_chk.sv
module thre_qual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] fifo_level,
    input logic       thr_wr,
    input logic       iir_rd,
    input logic       thre_ie,
    input logic       rls_pend,
    input logic       rda_pend,
    input logic       cto_pend,
    input logic       thre_flag,
    input logic       irq_pend,
    input logic [2:0] int_id
);
    // R6
    wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thre_flag);

    // R8
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && int_id == 3'b001) |=> !thre_flag);

    // R10
    rls_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rls_pend |-> (int_id == 3'b011));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rls_pend || rda_pend || cto_pend || thre_flag) |-> (int_id == 3'b000 && !irq_pend));

    // R11
    ie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !thre_ie |-> !thre_flag);

    // R4
    rise_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(thre_flag) && $past(thre_ie)) |-> ($past(fifo_level) == 5'd0));
endmodule

bind uart_thre_qual thre_qual_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_level (fifo_level),
    .thr_wr     (thr_wr),
    .iir_rd     (iir_rd),
    .thre_ie    (thre_ie),
    .rls_pend   (rls_pend),
    .rda_pend   (rda_pend),
    .cto_pend   (cto_pend),
    .thre_flag  (thre_flag),
    .irq_pend   (irq_pend),
    .int_id     (int_id)
);

// File: tb/uart_thre_qual_test.sv
`timescale 1ns/100ps
module uart_thre_qual_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] fifo_level = '0;
    logic       thr_wr = 1'b0, iir_rd = 1'b0, baud_tick = 1'b0;
    logic [1:0] data_bits_sel = 2'b11;
    logic       parity_en = 1'b0, thre_ie = 1'b1;
    logic       rls_pend = 1'b0, rda_pend = 1'b0, cto_pend = 1'b0;
    logic       thre_flag, irq_pend;
    logic [2:0] int_id;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_thre_qual uut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            baud_tick = 1'b1; step();
            baud_tick = 1'b0; step();
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fifo_level = '0; thr_wr = 0; iir_rd = 0; baud_tick = 0;
        data_bits_sel = 2'b11; parity_en = 0; thre_ie = 1;
        rls_pend = 0; rda_pend = 0; cto_pend = 0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic make_immediate();
        fifo_level = 5'd2; step();
        fifo_level = 5'd0; step();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step();
        check("R1 flag", thre_flag, 0);
        check("R1 id", int_id, 0);
        check("R1 irq", irq_pend, 0);
    endtask

    task automatic t_first_delay();
        do_reset();
        ticks(143);
        check("R2 early", thre_flag, 0);
        ticks(1);
        check("R12 delayed raise", thre_flag, 1);
        check("R2 id", int_id, 1);
    endtask

    task automatic t_format();
        do_reset();
        data_bits_sel = 2'b00; parity_en = 0;
        ticks(95);  check("R3 5N early", thre_flag, 0);
        ticks(1);   check("R3 5N raise", thre_flag, 1);
        do_reset();
        data_bits_sel = 2'b01; parity_en = 1;
        ticks(127); check("R3 6P early", thre_flag, 0);
        ticks(1);   check("R3 6P raise", thre_flag, 1);
    endtask

    task automatic t_immediate();
        do_reset();
        make_immediate();
        check("R4 flag", thre_flag, 1);
        check("R4 id", int_id, 1);
    endtask

    task automatic t_history();
        do_reset();
        make_immediate();
        thr_wr = 1; fifo_level = 5'd1; step();
        thr_wr = 0;
        check("R6 write clears", thre_flag, 0);
        fifo_level = 5'd0; step();
        check("R5 no immediate", thre_flag, 0);
        ticks(143); check("R5 early", thre_flag, 0);
        ticks(1);   check("R5 delayed", thre_flag, 1);
    endtask

    task automatic t_cancel();
        do_reset();
        ticks(50);
        thr_wr = 1; fifo_level = 5'd1; step();
        thr_wr = 0;
        ticks(150);
        check("R7 cancelled", thre_flag, 0);
        fifo_level = 5'd0; step();
        ticks(143); check("R7 full restart", thre_flag, 0);
        ticks(1);   check("R7 raise", thre_flag, 1);
    endtask

    task automatic t_iir_clear();
        do_reset();
        make_immediate();
        iir_rd = 1; step();
        iir_rd = 0;
        check("R8 cleared", thre_flag, 0);
        check("R8 id", int_id, 0);
        ticks(200);
        check("R8 stays low", thre_flag, 0);
    endtask

    task automatic t_iir_masked();
        do_reset();
        make_immediate();
        rda_pend = 1; #1;
        check("R9 id rda", int_id, 2);
        iir_rd = 1; step();
        iir_rd = 0; rda_pend = 0; #1;
        check("R9 kept", thre_flag, 1);
        check("R9 id", int_id, 1);
    endtask

    task automatic t_prio();
        do_reset();
        make_immediate();
        cto_pend = 1; #1; check("R10 cto", int_id, 6);
        rda_pend = 1; #1; check("R10 rda", int_id, 2);
        rls_pend = 1; #1; check("R10 rls", int_id, 3);
        rls_pend = 0; rda_pend = 0; cto_pend = 0; #1;
        check("R10 thre", int_id, 1);
        check("R10 irq", irq_pend, 1);
        thr_wr = 1; fifo_level = 5'd1; step();
        thr_wr = 0;
        check("R10 none id", int_id, 0);
        check("R10 none irq", irq_pend, 0);
    endtask

    task automatic t_enable();
        do_reset();
        thre_ie = 0;
        make_immediate();
        check("R11 hidden flag", thre_flag, 0);
        check("R11 hidden id", int_id, 0);
        check("R11 hidden irq", irq_pend, 0);
        iir_rd = 1; step();
        iir_rd = 0;
        thre_ie = 1; #1;
        check("R11 shown", thre_flag, 1);
        check("R11 id", int_id, 1);
    endtask

    initial begin
        t_reset();
        t_first_delay();
        t_format();
        t_immediate();
        t_history();
        t_cancel();
        t_iir_clear();
        t_iir_masked();
        t_prio();
        t_enable();
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule